// File: doc/BRIEF.md
# Clock, Reset and Power-Mode Controller

This controller sits beside an 8-bit processor core and owns its timing and power state. It divides the oscillator clock by two to form the state clock, and it counts twelve oscillator cycles per machine cycle. That is six states of two phases each. From this timing it issues one clock enable for the CPU and one for the peripherals.

The active-high reset pin passes through a two-stage synchronizer. The pin is then judged only during the fifth state of each machine cycle. The core reset is raised after the pin has been seen high in two consecutive machine cycles. It is dropped when a machine cycle sees the pin low. In both cases the change happens on the boundary into the sixth state.

Software selects low-power modes by writing an 8-bit power-control register. In idle, the CPU enable stops and the peripheral enable keeps running. An interrupt request ends idle. In power-down, the oscillator-stop request is raised and every enable stops. Only the reset pin brings the part back.

Top module: `pwr_clk_rst_ctl`

## Requirements
- R1: Outside power-down, `per_ce` is high on every second oscillator cycle and low on the others. `cpu_ce` is never high in two consecutive cycles, and it is only high when `per_ce` is.
- R2: The machine cycle is 12 oscillator cycles. The synchronized reset pin is judged only at the two phases of the fifth state, which are oscillator cycles 9 and 10 of the cycle.
- R3: `sys_rst` rises only after the pin has been judged high in two consecutive machine cycles. A high pulse that spans a single machine cycle never raises it.
- R4: A high pin level that is present at only one of the two fifth-state phases counts as low. Repeated one-cycle glitches never raise `sys_rst`.
- R5: `sys_rst` stays high while the pin keeps being judged high. It falls after the first low judgement. It changes only on the boundary into the sixth state.
- R6: While `sys_rst` is high, the power-control register reads 00h except bit 4, which keeps its earlier value.
- R7: Writing the register with bit 0 (idle) set stops `cpu_ce` while `per_ce` continues.
- R8: An `irq` pulse during idle clears bit 0, and `cpu_ce` resumes.
- R9: Writing bit 1 (power-down) raises `osc_stop` and holds both enables low. `irq` has no effect in this mode.
- R10: In power-down, a high reset pin drops `osc_stop` once it has passed the synchronizer. The qualified reset that follows clears bit 1.
- R11: When bits 0 and 1 are written together, only power-down is entered, and bit 0 reads 0.
- R12: A write is taken on a cycle where `ctl_we` and `cpu_ce` are both high. Writes made while `sys_rst` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw active-high reset pin |
| ctl_we | input | 1 | Power-control register write request |
| ctl_wdata | input | 8 | Write data; bit 0 idle, bit 1 power-down |
| irq | input | 1 | Enabled interrupt request |
| ctl_rdata | output | 8 | Power-control register contents |
| cpu_ce | output | 1 | CPU state-clock enable |
| per_ce | output | 1 | Peripheral state-clock enable |
| osc_stop | output | 1 | Request to stop the oscillator |
| sys_rst | output | 1 | Qualified synchronous core reset |

## Verification
The hardest case to reach from the ports is the reset-pin judgement during power-down. The state counter is frozen there, so the pin must first restart it through the synchronizer and then be judged twice.

The stimulus enters power-down by writing both mode bits together. It then raises the pin at an arbitrary point and holds it there. The bench's cycle model follows the counter through the restart and the two judgements.

Glitch and short-pulse stimulus deliberately hits the sampling window one phase at a time. This exercises the rejection path at both phases of the fifth state.

// File: rtl/pwr_clk_rst_ctl.sv
module pwr_clk_rst_ctl #(
  parameter int STATES      = 6,
  parameter int QUAL_CYCLES = 2
) (
  input  logic       osc_clk,
  input  logic       rst_pin,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       irq,
  output logic [7:0] ctl_rdata,
  output logic       cpu_ce,
  output logic       per_ce,
  output logic       osc_stop,
  output logic       sys_rst
);
  localparam int LAST   = 2 * STATES - 1;
  localparam int PW     = $clog2(2 * STATES);
  localparam int SAMP_A = 2 * (STATES - 2);
  localparam int SAMP_B = SAMP_A + 1;
  localparam int CW     = $clog2(QUAL_CYCLES + 1);

  logic [1:0]    rs;
  logic [PW-1:0] ph;
  logic          held_a;
  logic [CW-1:0] qcnt;
  logic          rst_q;
  logic [7:0]    pcon;

  wire pd   = pcon[1];
  wire idl  = pcon[0];
  wire run  = ~(pd & ~rs[1]);
  wire tick = run & ph[0];
  wire hit  = held_a & rs[1];
  wire [CW-1:0] qnext = !hit ? '0 :
                        (qcnt == CW'(QUAL_CYCLES)) ? qcnt : qcnt + 1'b1;

  assign osc_stop  = ~run;
  assign per_ce    = tick & ~pd;
  assign cpu_ce    = tick & ~pd & ~idl;
  assign sys_rst   = rst_q;
  assign ctl_rdata = pcon;

  always_ff @(posedge osc_clk) begin
    rs <= {rs[0], rst_pin};
    if (run) begin
      ph <= (ph == PW'(LAST)) ? '0 : ph + 1'b1;
      if (ph == PW'(SAMP_A)) held_a <= rs[1];
      if (ph == PW'(SAMP_B)) begin
        qcnt  <= qnext;
        rst_q <= (qnext == CW'(QUAL_CYCLES));
      end
    end
  end

  always_ff @(posedge osc_clk) begin
    if (rst_q)
      pcon <= pcon & 8'h10;
    else if (ctl_we && cpu_ce)
      pcon <= {ctl_wdata[7:1], ctl_wdata[0] & ~ctl_wdata[1]};
    else if (irq && idl && !pd)
      pcon[0] <= 1'b0;
  end
endmodule

module pwr_clk_rst_ctl_chk #(
  parameter int PW      = 4,
  parameter int EDGE_PH = 10
) (
  input logic          clk,
  input logic          irq,
  input logic          cpu_ce,
  input logic          per_ce,
  input logic          osc_stop,
  input logic          sys_rst,
  input logic [7:0]    pcon,
  input logic [PW-1:0] ph
);
  logic armed;
  always_ff @(posedge clk) if (sys_rst) armed <= 1'b1;

  // R1
  cpu_gap_chk: assert property (@(posedge clk) disable iff (!armed) cpu_ce |=> !cpu_ce);
  // R1
  cpu_within_per_chk: assert property (@(posedge clk) disable iff (!armed) cpu_ce |-> per_ce);
  // R5
  rst_edge_chk: assert property (@(posedge clk) disable iff (!armed) !$stable(sys_rst) |-> ph == PW'(EDGE_PH));
  // R6
  rst_clears_modes_chk: assert property (@(posedge clk) disable iff (!armed) sys_rst |=> pcon[1:0] == 2'b00);
  // R8
  idle_wake_chk: assert property (@(posedge clk) disable iff (!armed || sys_rst) (irq && pcon[0] && !pcon[1]) |=> !pcon[0]);
  // R9
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!armed) osc_stop |-> (!per_ce && !cpu_ce));
  // R11
  mode_excl_chk: assert property (@(posedge clk) disable iff (!armed) !(pcon[0] && pcon[1]));
endmodule

bind pwr_clk_rst_ctl pwr_clk_rst_ctl_chk #(.PW(PW), .EDGE_PH(SAMP_B + 1)) chk_i (
  .clk(osc_clk), .irq(irq), .cpu_ce(cpu_ce), .per_ce(per_ce), .osc_stop(osc_stop),
  .sys_rst(sys_rst), .pcon(pcon), .ph(ph)
);

// File: tb/pwr_clk_rst_ctl_tb.sv
module pwr_clk_rst_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_pin = 1'b1, ctl_we = 1'b0, irq = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic cpu_ce, per_ce, osc_stop, sys_rst;
  int checks = 0, errors = 0;
  bit done = 0;

  pwr_clk_rst_ctl dut_i (.osc_clk(clk), .rst_pin(rst_pin), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .irq(irq), .ctl_rdata(ctl_rdata), .cpu_ce(cpu_ce), .per_ce(per_ce), .osc_stop(osc_stop),
    .sys_rst(sys_rst));

  always #10 clk = ~clk;

  // behavioural reference: phase counter, pin history, judgement count
  int  m_ph = 0, m_good = 0;
  bit  m_s1 = 0, m_s2 = 0, m_half = 0, m_rst = 0, m_armed = 0;
  bit [7:0] m_reg = 8'h00;

  function automatic bit m_run();  return !(m_reg[1] && !m_s2); endfunction
  function automatic bit m_tick(); return m_run() && (m_ph % 2 == 1); endfunction
  function automatic bit m_per();  return m_tick() && !m_reg[1]; endfunction
  function automatic bit m_cpu();  return m_per() && !m_reg[0]; endfunction

  always @(posedge clk) begin
    bit run_o, cpu_o, rst_o;
    run_o = m_run(); cpu_o = m_cpu(); rst_o = m_rst;
    if (run_o) begin
      if (m_ph == 8) m_half = m_s2;
      if (m_ph == 9) begin
        if (m_half && m_s2) m_good = (m_good >= 2) ? 2 : m_good + 1;
        else m_good = 0;
        m_rst = (m_good == 2);
      end
      m_ph = (m_ph + 1) % 12;
    end
    if (rst_o) m_reg = m_reg & 8'h10;
    else if (ctl_we && cpu_o) begin
      m_reg = ctl_wdata;
      if (ctl_wdata[1]) m_reg[0] = 1'b0;
    end else if (irq && m_reg[0] && !m_reg[1]) m_reg[0] = 1'b0;
    m_s2 = m_s1; m_s1 = rst_pin;
    if (m_rst) m_armed = 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (m_armed && !done) begin
    chk(per_ce == m_per(),   "R1 R7 R9 per_ce", per_ce, m_per());
    chk(cpu_ce == m_cpu(),   "R1 R7 R8 cpu_ce", cpu_ce, m_cpu());
    chk(osc_stop == !m_run(),"R9 R10 osc_stop", osc_stop, !m_run());
    chk(sys_rst == m_rst,    "R2 R3 R5 sys_rst", sys_rst, m_rst);
    chk(ctl_rdata == m_reg,  "R6 R11 R12 ctl_rdata", ctl_rdata, m_reg);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = d;
    #1;
    while (!cpu_ce) begin @(negedge clk); #1; end
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic count(input int n, output int nc, output int np, output int nrst);
    nc = 0; np = 0; nrst = 0;
    repeat (n) begin
      @(negedge clk); #2;
      nc += cpu_ce; np += per_ce; nrst += sys_rst;
    end
  endtask

  initial begin
    int nc, np, nr;
    cyc(60);
    #2;
    chk(sys_rst == 1'b1, "R3 reset qualified", sys_rst, 1);
    chk(ctl_rdata == 8'h00, "R6 reset state", ctl_rdata, 0);
    rst_pin = 1'b0;
    cyc(40); #2;
    chk(sys_rst == 1'b0, "R5 reset released", sys_rst, 0);
    wr(8'hF4); cyc(2); #2;
    chk(ctl_rdata == 8'hF4, "R12 write taken", ctl_rdata, 8'hF4);
    count(24, nc, np, nr);
    chk(np == 12, "R1 per_ce rate", np, 12);
    chk(nc == 12, "R1 cpu_ce rate", nc, 12);
    wr(8'hF5);
    count(24, nc, np, nr);
    chk(nc == 0, "R7 idle cpu stopped", nc, 0);
    chk(np == 12, "R7 idle per runs", np, 12);
    @(negedge clk); irq = 1'b1; @(negedge clk); irq = 1'b0; #2;
    chk(ctl_rdata[0] == 1'b0, "R8 idle bit cleared", ctl_rdata[0], 0);
    count(24, nc, np, nr);
    chk(nc == 12, "R8 cpu resumed", nc, 12);
    // R3: one machine cycle of pin high
    @(negedge clk); rst_pin = 1'b1; cyc(12); rst_pin = 1'b0;
    count(48, nc, np, nr);
    chk(nr == 0, "R3 short pulse ignored", nr, 0);
    // R4: one-cycle glitches at every phase offset
    for (int k = 0; k < 24; k++) begin
      @(negedge clk); rst_pin = 1'b1; @(negedge clk); rst_pin = 1'b0; cyc(k % 13);
    end
    count(36, nc, np, nr);
    chk(nr == 0, "R4 glitches ignored", nr, 0);
    // R6 R12: reset keeps bit 4, writes during reset dropped
    @(negedge clk); rst_pin = 1'b1; cyc(40);
    wr(8'hFF); cyc(2); #2;
    chk(sys_rst == 1'b1, "R2 reset held", sys_rst, 1);
    chk(ctl_rdata == 8'h10, "R6 R12 bit4 kept write ignored", ctl_rdata, 8'h10);
    rst_pin = 1'b0; cyc(40);
    // R11 R9: both bits -> power-down
    wr(8'h03); cyc(2); #2;
    chk(ctl_rdata[1:0] == 2'b10, "R11 pd priority", ctl_rdata[1:0], 2);
    chk(osc_stop == 1'b1, "R9 osc stopped", osc_stop, 1);
    @(negedge clk); irq = 1'b1; @(negedge clk); irq = 1'b0;
    count(30, nc, np, nr);
    chk(nc + np == 0, "R9 enables off", nc + np, 0);
    chk(ctl_rdata[1] == 1'b1, "R9 irq no wake", ctl_rdata[1], 1);
    // R10: reset wakes
    @(negedge clk); rst_pin = 1'b1; cyc(3); #2;
    chk(osc_stop == 1'b0, "R10 osc restart", osc_stop, 0);
    cyc(40); #2;
    chk(ctl_rdata[1:0] == 2'b00, "R10 pd cleared", ctl_rdata[1:0], 0);
    rst_pin = 1'b0; cyc(40);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule